// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block raises a DMA request toward an external bus master and follows the acknowledge that the master returns. A single configuration word, written by software, selects between two handshake styles. In pulse mode the request falls each time the master releases its acknowledge, and then stays low for a programmable guard interval. In burst mode the request falls once a programmed number of words has moved, and it re-arms only after the master lets go of the acknowledge. The burst length is coded as a power-of-two exponent, and the top code means an open-ended burst.

The same word sets the active level of the request pin, the acknowledge pin and the interrupt pin. It also holds software overrides that force the request or interrupt pin to a fixed level, a guard interval in clock cycles, and an initialization flag that hardware can read. Each write produces a one-cycle change event. The request, acknowledge and interrupt are registered at the pins, and polarity is applied after the override selection.

Top module: `dreq_handshake`

## Requirements
- R1: After reset the request and interrupt pins are high (inactive in active-low form), the change event is low, the init flag is 1, and the configuration is pulse mode, burst code 15 and guard 4.
- R2: In burst mode (word bit 4 = 1) with burst code N in 0..14 (bits 3:0), the request falls after exactly 2^N words. A word is one clock with the acknowledge active and `data_strobe` high.
- R3: In pulse mode (bit 4 = 0) the request stays asserted while the acknowledge is active. It falls after the acknowledge is released, and with `req_pend` held high it stays low for exactly G+1 clocks, where G is bits 20:13.
- R4: After a finite burst completes, the request stays deasserted while the acknowledge remains active. It re-asserts only after the acknowledge is released.
- R5: In burst mode, burst code 15 never ends the burst on a word count. The request stays asserted across any number of words and falls when the acknowledge is released.
- R6: When the request override bit (bit 6) is 1, the request pin shows the request value bit (bit 7), whatever the handshake state.
- R7: Polarity bits set active-high when 1 and active-low when 0: bit 8 for the request pin, bit 9 for the acknowledge pin and bit 12 for the interrupt pin.
- R8: When the interrupt override bit (bit 10) is 1, the interrupt pin shows the interrupt value bit (bit 11). Otherwise it follows `irq_src`.
- R9: Every clock with `cfg_we` high is followed by exactly one clock with `cfg_event` high, and no write gives no event.
- R10: `init_mode` shows the stored init bit (bit 5), which resets to 1 and is cleared by a write.
- R11: The request never asserts while `req_pend` is low. In pulse mode the burst code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 21 | Configuration word |
| req_pend | input | 1 | A transfer is waiting; gates the request |
| dack_pin | input | 1 | Acknowledge from the master, polarity set by bit 9 |
| data_strobe | input | 1 | Marks a data word during acknowledge |
| irq_src | input | 1 | Internal interrupt source, active high |
| drq_pin | output | 1 | Registered request pin |
| irq_pin | output | 1 | Registered interrupt pin |
| cfg_event | output | 1 | One-cycle event after each configuration write |
| init_mode | output | 1 | Stored initialization flag |

## Verification
The assertions check on every cycle that the request holds while a pulse-mode acknowledge is active and drops once it is released, that a completed burst or a held acknowledge in the release state keeps the request low, that an idle controller never raises it without a pending transfer, that the forced and polarity-mapped pin levels are correct, and that the change event follows the write strobe. Only the bench scenarios can show the exact burst word counts across a sweep of burst codes, the exact guard lengths across several guard values and both acknowledge polarities, the open-ended burst, and the re-arm latency after release.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
    localparam int EXP_W   = 4;
    localparam int GUARD_W = 8;
    localparam int CNT_W   = (1 << EXP_W) - 1;
    localparam int CFG_W   = GUARD_W + 9 + EXP_W;
    localparam logic [EXP_W-1:0]   CODE_OPEN = '1;
    localparam logic [GUARD_W-1:0] GUARD_RST = 8'd4;

    typedef struct packed {
        logic [GUARD_W-1:0] guard;
        logic               irq_pol;
        logic               irq_val;
        logic               irq_ovr;
        logic               dack_pol;
        logic               drq_pol;
        logic               drq_val;
        logic               drq_ovr;
        logic               init;
        logic               burst;
        logic [EXP_W-1:0]   code;
    } cfg_t;

    typedef enum logic [2:0] {
        HS_IDLE, HS_REQ, HS_XFER, HS_GUARD, HS_HOLD
    } hs_state_e;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c       = '0;
        c.code  = CODE_OPEN;
        c.init  = 1'b1;
        c.guard = GUARD_RST;
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] burst_last(input logic [EXP_W-1:0] code);
        return (CNT_W'(1) << code) - CNT_W'(1);
    endfunction
endpackage

// File: rtl/dreq_cfg.sv
module dreq_cfg
    import dreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_reset();
            evt <= 1'b0;
        end else begin
            evt <= we;
            if (we) cfg <= cfg_t'(wdata);
        end
    end

    p_evt_on_r9:  assert property (@(posedge clk) disable iff (rst) we |=> evt);
    p_evt_off_r9: assert property (@(posedge clk) disable iff (rst) !we |=> !evt);
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
    import dreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               burst,
    input  logic [EXP_W-1:0]   code,
    input  logic [GUARD_W-1:0] guard,
    input  logic               req_pend,
    input  logic               dack_act,
    input  logic               strobe,
    output logic               drq_int
);
    hs_state_e          st, st_n;
    logic [CNT_W-1:0]   wcnt, wcnt_n;
    logic [GUARD_W-1:0] gcnt, gcnt_n;
    logic               word, done, open_b;

    assign open_b  = (code == CODE_OPEN);
    assign word    = dack_act && strobe && burst;
    assign done    = word && !open_b && (wcnt == burst_last(code));
    assign drq_int = (st == HS_REQ) || (st == HS_XFER);

    always_comb begin
        st_n   = st;
        gcnt_n = gcnt;
        unique case (st)
            HS_IDLE:  if (req_pend) st_n = HS_REQ;
            HS_REQ: begin
                if (done)          st_n = HS_HOLD;
                else if (dack_act) st_n = HS_XFER;
                else if (!req_pend) st_n = HS_IDLE;
            end
            HS_XFER: begin
                if (burst) begin
                    if (done)           st_n = HS_HOLD;
                    else if (!dack_act) st_n = open_b ? HS_IDLE : HS_REQ;
                end else if (!dack_act) begin
                    if (guard == '0) st_n = HS_IDLE;
                    else begin
                        st_n   = HS_GUARD;
                        gcnt_n = guard - GUARD_W'(1);
                    end
                end
            end
            HS_GUARD: begin
                if (gcnt == '0) st_n = HS_IDLE;
                else            gcnt_n = gcnt - GUARD_W'(1);
            end
            HS_HOLD:  if (!dack_act) st_n = HS_IDLE;
            default:  st_n = HS_IDLE;
        endcase
    end

    always_comb begin
        if (st_n != HS_REQ && st_n != HS_XFER) wcnt_n = '0;
        else if (word)                         wcnt_n = wcnt + CNT_W'(1);
        else                                   wcnt_n = wcnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= HS_IDLE;
            wcnt <= '0;
            gcnt <= '0;
        end else begin
            st   <= st_n;
            wcnt <= wcnt_n;
            gcnt <= gcnt_n;
        end
    end

    p_burst_end_r2: assert property (@(posedge clk) disable iff (rst)
        (drq_int && burst && !open_b && word && wcnt == burst_last(code)) |=> !drq_int);
    p_pulse_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st == HS_XFER && !burst && dack_act) |=> drq_int);
    p_pulse_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (st == HS_XFER && !burst && !dack_act) |=> !drq_int);
    p_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        (st == HS_HOLD && dack_act) |=> !drq_int);
    p_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (!drq_int && !req_pend) |=> !drq_int);
endmodule

// File: rtl/dreq_pin_out.sv
module dreq_pin_out #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic ovr,
    input  logic val,
    input  logic pol,
    output logic pin
);
    logic lvl;
    assign lvl = ovr ? val : src;

    always_ff @(posedge clk) begin
        if (rst) pin <= RST_VAL;
        else     pin <= pol ? lvl : !lvl;
    end

    // R6 on the request instance, R8 on the interrupt instance
    p_force_r6: assert property (@(posedge clk) disable iff (rst)
        $past(ovr) |-> pin == ($past(pol) ? $past(val) : !$past(val)));
    p_pol_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(ovr) |-> pin == ($past(pol) ? $past(src) : !$past(src)));
endmodule

// File: rtl/dreq_handshake.sv
module dreq_handshake
    import dreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_pend,
    input  logic             dack_pin,
    input  logic             data_strobe,
    input  logic             irq_src,
    output logic             drq_pin,
    output logic             irq_pin,
    output logic             cfg_event,
    output logic             init_mode
);
    cfg_t cfg;
    logic dack_q, strb_q, dack_act, drq_int;

    dreq_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .evt(cfg_event)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dack_q <= 1'b1;
            strb_q <= 1'b0;
        end else begin
            dack_q <= dack_pin;
            strb_q <= data_strobe;
        end
    end

    assign dack_act  = cfg.dack_pol ? dack_q : !dack_q;
    assign init_mode = cfg.init;

    dreq_fsm u_fsm (
        .clk(clk), .rst(rst), .burst(cfg.burst), .code(cfg.code),
        .guard(cfg.guard), .req_pend(req_pend), .dack_act(dack_act),
        .strobe(strb_q), .drq_int(drq_int)
    );

    dreq_pin_out #(.RST_VAL(1'b1)) u_drq_pin (
        .clk(clk), .rst(rst), .src(drq_int), .ovr(cfg.drq_ovr),
        .val(cfg.drq_val), .pol(cfg.drq_pol), .pin(drq_pin)
    );

    dreq_pin_out #(.RST_VAL(1'b1)) u_irq_pin (
        .clk(clk), .rst(rst), .src(irq_src), .ovr(cfg.irq_ovr),
        .val(cfg.irq_val), .pol(cfg.irq_pol), .pin(irq_pin)
    );

    p_init_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> init_mode == $past(cfg_wdata[5]));
endmodule

// File: tb/dreq_handshake_bench.sv
module dreq_handshake_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [20:0] cfg_wdata = '0;
    logic req_pend = 1'b0;
    logic dack_pin = 1'b1;
    logic data_strobe = 1'b0;
    logic irq_src = 1'b0;
    logic drq_pin, irq_pin, cfg_event, init_mode;

    int checks = 0;
    int errors = 0;
    logic cur_dpol = 1'b0;
    logic cur_kpol = 1'b0;

    always #10 clk = ~clk;

    dreq_handshake u_dreq_handshake (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_pend(req_pend), .dack_pin(dack_pin), .data_strobe(data_strobe),
        .irq_src(irq_src), .drq_pin(drq_pin), .irq_pin(irq_pin),
        .cfg_event(cfg_event), .init_mode(init_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [20:0] mk(input int code, input bit burst, input bit init,
        input bit dov, input bit dval, input bit dpol, input bit kpol,
        input bit iov, input bit ival, input bit ipol, input int guard);
        logic [20:0] w;
        w = '0;
        w[3:0] = code[3:0]; w[4] = burst; w[5] = init;
        w[6] = dov; w[7] = dval; w[8] = dpol; w[9] = kpol;
        w[10] = iov; w[11] = ival; w[12] = ipol; w[20:13] = guard[7:0];
        return w;
    endfunction

    function automatic bit drq_on();
        return drq_pin == cur_dpol;
    endfunction

    task automatic set_dack(input bit act);
        dack_pin = act ? cur_kpol : !cur_kpol;
    endtask

    task automatic wcfg(input logic [20:0] w);
        cfg_wdata = w;
        cfg_we = 1'b1;
        cur_kpol = w[9];
        set_dack(1'b0);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_dpol = w[8];
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_on(input string req);
        int n = 0;
        while (!drq_on() && n < 50) begin @(negedge clk); n++; end
        chk(drq_on(), req, drq_pin, cur_dpol);
    endtask

    task automatic pulse_case(input int g, input bit kp, input bit dp);
        int a, i;
        req_pend = 1'b1;
        wcfg(mk(0, 0, 1, 0, 0, dp, kp, 0, 0, 0, g));
        wait_on("R3");
        set_dack(1'b1); data_strobe = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(drq_on(), "R3/R11 hold during ack, code 0 ignored", drq_pin, cur_dpol);
        end
        set_dack(1'b0); data_strobe = 1'b0;
        a = 0;
        @(negedge clk);
        while (drq_on() && a < 20) begin a++; @(negedge clk); end
        chk(a == 2, "R3 drop latency", a, 2);
        i = 0;
        while (!drq_on() && i < 300) begin i++; @(negedge clk); end
        chk(i == g + 1, "R3 guard length", i, g + 1);
    endtask

    task automatic burst_case(input int n);
        int c, i;
        req_pend = 1'b1;
        wcfg(mk(n, 1, 1, 0, 0, 0, 0, 0, 0, 0, 4));
        wait_on("R2");
        set_dack(1'b1); data_strobe = 1'b1;
        c = 0;
        @(negedge clk);
        while (drq_on() && c < 200) begin c++; @(negedge clk); end
        chk(c == (1 << n) + 1, "R2 burst word count", c, (1 << n) + 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!drq_on(), "R4 no re-arm while ack held", drq_pin, !cur_dpol);
        end
        set_dack(1'b0); data_strobe = 1'b0;
        i = 0;
        @(negedge clk);
        while (!drq_on() && i < 20) begin i++; @(negedge clk); end
        chk(i == 3, "R4 re-arm after release", i, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(drq_pin == 1'b1, "R1 drq idle", drq_pin, 1);
        chk(irq_pin == 1'b1, "R1 irq idle", irq_pin, 1);
        chk(cfg_event == 1'b0, "R1 event low", cfg_event, 0);
        chk(init_mode == 1'b1, "R1 init set", init_mode, 1);

        // R11 gate, then default guard of 4 (R1)
        for (int k = 0; k < 8; k++) @(negedge clk);
        chk(!drq_on(), "R11 no request without pending", drq_pin, 1);
        req_pend = 1'b1;
        wait_on("R11 request after pending");
        set_dack(1'b1);
        @(negedge clk); @(negedge clk);
        set_dack(1'b0);
        begin
            int i = 0;
            repeat (3) @(negedge clk);
            while (!drq_on() && i < 50) begin i++; @(negedge clk); end
            chk(i == 5, "R1 default guard 4 (pulse mode)", i + 1 - 1, 5);
        end

        // R9 change event
        cfg_wdata = mk(15, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4);
        cfg_we = 1'b1;
        @(negedge clk);
        chk(cfg_event == 1'b1, "R9 event after write 1", cfg_event, 1);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_event == 1'b1, "R9 event after write 2", cfg_event, 1);
        @(negedge clk);
        chk(cfg_event == 1'b0, "R9 single pulse per write", cfg_event, 0);

        // R10 init flag
        wcfg(mk(15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4));
        chk(init_mode == 1'b0, "R10 init cleared", init_mode, 0);

        // R3 pulse sweep, R7 acknowledge/request polarity
        pulse_case(0, 0, 0);
        pulse_case(1, 0, 0);
        pulse_case(2, 1, 1);
        pulse_case(5, 1, 0);
        pulse_case(3, 0, 1);

        // R2 / R4 burst sweep
        for (int n = 0; n <= 6; n++) burst_case(n);

        // R5 open-ended burst
        req_pend = 1'b1;
        wcfg(mk(15, 1, 1, 0, 0, 0, 0, 0, 0, 0, 4));
        wait_on("R5");
        set_dack(1'b1); data_strobe = 1'b1;
        begin
            int on = 0;
            for (int k = 0; k < 100; k++) begin @(negedge clk); if (drq_on()) on++; end
            chk(on == 100, "R5 request held through words", on, 100);
        end
        set_dack(1'b0); data_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk(!drq_on(), "R5 drop on release", drq_pin, !cur_dpol);
        @(negedge clk);
        chk(drq_on(), "R5 re-arm", drq_pin, cur_dpol);

        // R6 / R7 request override and polarity sweep, no pending
        req_pend = 1'b0;
        for (int c = 0; c < 8; c++) begin
            logic ov, vl, pl, x;
            ov = c[0]; vl = c[1]; pl = c[2];
            wcfg(mk(15, 0, 1, ov, vl, pl, 0, 0, 0, 0, 4));
            x = ov ? vl : 1'b0;
            chk(drq_pin == (pl ? x : !x), "R6/R7 drq override/polarity", drq_pin, pl ? x : !x);
        end
        req_pend = 1'b1;
        wcfg(mk(15, 0, 1, 1, 0, 0, 0, 0, 0, 0, 4));
        repeat (5) @(negedge clk);
        chk(drq_pin == 1'b1, "R6 forced off while pending", drq_pin, 1);

        // R8 / R7 interrupt sweep
        for (int c = 0; c < 16; c++) begin
            logic ov, vl, pl, x;
            ov = c[0]; vl = c[1]; pl = c[2];
            irq_src = c[3];
            wcfg(mk(15, 0, 1, 0, 0, 0, 0, ov, vl, pl, 4));
            x = ov ? vl : c[3];
            chk(irq_pin == (pl ? x : !x), "R8/R7 irq override/polarity", irq_pin, pl ? x : !x);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule